// File: doc/BRIEF.md
# Direct-Mapped Instruction Cache with Speculative Bus Kill

This block is a read-only, direct-mapped instruction cache on a processor's local fetch bus. Every accepted fetch is looked up in a tag array and a data array. In that same cycle the block also opens a request on the external memory bus. When the lookup hits, a kill strobe goes high in that same cycle beside the request strobe. The bus controller then discards the request, and the longword reaches the processor one cycle later through registered outputs.

On a miss the external request is allowed to run as a 16-byte line burst. The burst returns four longwords in wrapping order, starting with the one that was asked for. That first longword goes straight to the processor. All four longwords are gathered in a fill buffer. One cycle after the fourth beat, the whole line is written into the arrays and its single valid bit is set. The fetch port is not ready from the miss until that write is done.

The controller has three states. `S_IDLE` accepts fetches. `S_FILL` gathers burst beats. `S_COMMIT` writes the line. The transitions are: miss (`S_IDLE`→`S_FILL`), hit or no request (`S_IDLE`→`S_IDLE`), waiting for beats (`S_FILL`→`S_FILL`), fourth beat (`S_FILL`→`S_COMMIT`) and write done (`S_COMMIT`→`S_IDLE`).

Top module: `icache_kill_top`

## Requirements
- R1: After reset every line is invalid. `fetch_ready` is 1, `rsp_valid` is 0, and the first fetch to any address misses.
- R2: `bus_start` is 1 in the same cycle as every accepted fetch (`fetch_req` while `fetch_ready`), and `bus_addr` equals `fetch_addr` in that cycle.
- R3: `bus_kill` is 1 in an accepted fetch's cycle exactly when the lookup hits, meaning the line at index `fetch_addr[IW+3:4]` is valid and its stored tag equals `fetch_addr[AW-1:IW+4]`. Otherwise it is 0.
- R4: On a hit, `rsp_valid` is 1 in the next cycle and `rsp_data` holds the longword selected by `fetch_addr[3:2]` (0 = lowest word of the line).
- R5: On a miss the controller enters `S_FILL` and `fetch_ready` drops in the next cycle. Burst beat k (k = 0..3, counted only while filling) carries line word (c+k) mod 4, where c is `fetch_addr[3:2]` of the missing fetch. Idle cycles between beats are allowed.
- R6: One cycle after the first beat of a burst, `rsp_valid` is 1 and `rsp_data` equals that beat's data (the critical longword).
- R7: The line becomes valid only as a whole. `fetch_ready` stays 0 through the `S_COMMIT` cycle that follows the fourth beat. It returns to 1 the cycle after, and from then on all four words of the line hit with the burst's data.
- R8: Two lines with equal index and different tags replace each other. After the second is filled, the first misses.
- R9: `inv_all` clears every valid bit in the next cycle. If it arrives in the `S_COMMIT` cycle, the line being written stays invalid.
- R10: A fetch presented while `fetch_ready` is 0 is ignored: no `bus_start`, no `bus_kill` and no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inv_all | input | 1 | Invalidate every line |
| fetch_req | input | 1 | Fetch request from the processor |
| fetch_addr | input | AW-2 | Longword address of the fetch (byte address bits AW-1:2) |
| fetch_ready | output | 1 | Fetch port accepts a request this cycle |
| rsp_valid | output | 1 | Registered: longword returned to the processor |
| rsp_data | output | 32 | Registered returned longword |
| bus_start | output | 1 | External request strobe, one per accepted fetch |
| bus_kill | output | 1 | Cancels this cycle's external request (lookup hit) |
| bus_addr | output | AW-2 | Longword address of the external request |
| bus_beat_valid | input | 1 | Burst beat present |
| bus_beat_data | input | 32 | Burst beat longword |

## Verification
The bench builds the block with `LINES = 8` and `AW = 16`, giving three index bits and a nine-bit tag. At that size, addresses 128 bytes apart land on the same line, so conflict replacement comes within reach after a few fills. The small address space also lets the bench keep a tag-and-valid model of every line. Its fills start at different critical words and leave idle gaps between beats, which exercises the wrap order. An invalidate is also driven into the commit cycle.

// File: rtl/icache_kill_pkg.sv
package icache_kill_pkg;
    localparam int unsigned WORDS_PER_LINE = 4;

    typedef logic [31:0] word_t;
    typedef logic [WORDS_PER_LINE-1:0][31:0] line_t;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_FILL   = 2'd1,
        S_COMMIT = 2'd2
    } ic_state_e;
endpackage

// File: rtl/icache_store.sv
module icache_store
    import icache_kill_pkg::*;
#(
    parameter int unsigned LINES = 512,
    parameter int unsigned TW    = 19,
    localparam int unsigned IW   = $clog2(LINES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inv_all,
    input  logic [IW-1:0] rd_idx,
    output logic          rd_valid,
    output logic [TW-1:0] rd_tag,
    output line_t         rd_line,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [TW-1:0] wr_tag,
    input  line_t         wr_line
);
    logic [LINES-1:0] valid_q;
    logic [TW-1:0]    tag_q  [LINES];
    line_t            data_q [LINES];

    always_ff @(posedge clk) begin
        if (!rst_n || inv_all) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx]  <= wr_tag;
            data_q[wr_idx] <= wr_line;
        end
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];
    assign rd_line  = data_q[rd_idx];

    // R9: invalidate empties the whole valid vector on the next edge
    a_r9_inv_clears: assert property (@(posedge clk) disable iff (!rst_n)
        inv_all |=> (valid_q == '0));
endmodule

// File: rtl/icache_fill.sv
module icache_fill
    import icache_kill_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] crit,
    input  logic       accept,
    input  word_t      beat_data,
    output line_t      line,
    output logic       first_beat,
    output logic       last_beat
);
    logic [1:0] cnt_q;
    logic [1:0] slot;
    line_t      words_q;

    assign slot       = crit + cnt_q;
    assign first_beat = accept && (cnt_q == 2'd0);
    assign last_beat  = accept && (cnt_q == 2'd3);
    assign line       = words_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= 2'd0;
        end else if (accept) begin
            cnt_q <= cnt_q + 2'd1;
        end
    end

    always_ff @(posedge clk) begin
        if (accept) begin
            words_q[slot] <= beat_data;
        end
    end

    // R5: after the fourth beat the beat counter starts over
    a_r5_count_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        last_beat |=> (cnt_q == 2'd0));
endmodule

// File: rtl/icache_ctrl.sv
module icache_ctrl
    import icache_kill_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      fetch_req,
    input  logic      lookup_hit,
    input  logic      last_beat,
    output ic_state_e state,
    output logic      fetch_ready,
    output logic      fill_active,
    output logic      commit
);
    ic_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (fetch_req && !lookup_hit) state_d = S_FILL;
            S_FILL:   if (last_beat)                state_d = S_COMMIT;
            S_COMMIT:                               state_d = S_IDLE;
            default:                                state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        fetch_ready = 1'b0;
        fill_active = 1'b0;
        commit      = 1'b0;
        unique case (state_q)
            S_IDLE:   fetch_ready = 1'b1;
            S_FILL:   fill_active = 1'b1;
            S_COMMIT: commit      = 1'b1;
            default:  fetch_ready = 1'b0;
        endcase
    end

    assign state = state_q;

    // R5: a missing fetch in idle leads to the fill state
    a_r5_miss_to_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && fetch_req && !lookup_hit) |=> (state_q == S_FILL));
    // R7: the commit lasts exactly one cycle and hands back to idle
    a_r7_commit_once: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_COMMIT) |=> (state_q == S_IDLE));
    // R7: the fill state ends only on the fourth beat
    a_r7_fill_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FILL && !last_beat) |=> (state_q == S_FILL));
endmodule

// File: rtl/icache_kill_top.sv
module icache_kill_top
    import icache_kill_pkg::*;
#(
    parameter int unsigned AW    = 32,
    parameter int unsigned LINES = 512
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inv_all,
    input  logic          fetch_req,
    input  logic [AW-1:2] fetch_addr,
    output logic          fetch_ready,
    output logic          rsp_valid,
    output logic [31:0]   rsp_data,
    output logic          bus_start,
    output logic          bus_kill,
    output logic [AW-1:2] bus_addr,
    input  logic          bus_beat_valid,
    input  logic [31:0]   bus_beat_data
);
    localparam int unsigned IW = $clog2(LINES);
    localparam int unsigned TW = AW - 4 - IW;

    ic_state_e     state;
    logic          fill_active, commit;
    logic          rd_valid, lookup_hit;
    logic [TW-1:0] rd_tag;
    line_t         rd_line, fill_line;
    word_t         hit_word;
    logic          first_beat, last_beat, accept;
    logic [AW-1:2] miss_q;

    logic [IW-1:0] idx;
    logic [TW-1:0] tag;
    logic [1:0]    wsel;

    assign idx  = fetch_addr[IW+3:4];
    assign tag  = fetch_addr[AW-1:IW+4];
    assign wsel = fetch_addr[3:2];

    icache_store #(.LINES(LINES), .TW(TW)) u_store (
        .clk(clk), .rst_n(rst_n), .inv_all(inv_all),
        .rd_idx(idx), .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_line(rd_line),
        .wr_en(commit), .wr_idx(miss_q[IW+3:4]), .wr_tag(miss_q[AW-1:IW+4]),
        .wr_line(fill_line)
    );

    assign lookup_hit = rd_valid && (rd_tag == tag);
    assign hit_word   = rd_line[wsel];

    icache_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .lookup_hit(lookup_hit),
        .last_beat(last_beat), .state(state), .fetch_ready(fetch_ready),
        .fill_active(fill_active), .commit(commit)
    );

    assign accept = bus_beat_valid && fill_active;

    icache_fill u_fill (
        .clk(clk), .rst_n(rst_n), .crit(miss_q[3:2]), .accept(accept),
        .beat_data(bus_beat_data), .line(fill_line),
        .first_beat(first_beat), .last_beat(last_beat)
    );

    assign bus_start = fetch_req && fetch_ready;
    assign bus_kill  = bus_start && lookup_hit;
    assign bus_addr  = fetch_addr;

    always_ff @(posedge clk) begin
        if (bus_start && !lookup_hit) miss_q <= fetch_addr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= bus_kill || first_beat;
            if (bus_kill)        rsp_data <= hit_word;
            else if (first_beat) rsp_data <= bus_beat_data;
        end
    end

    // R4: a killed request is answered from the array on the next cycle
    a_r4_hit_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        bus_kill |=> (rsp_valid && rsp_data == $past(hit_word)));
    // R6: the first burst beat is forwarded on the next cycle
    a_r6_crit_fwd: assert property (@(posedge clk) disable iff (!rst_n)
        first_beat |=> (rsp_valid && rsp_data == $past(bus_beat_data)));
    // R10: outside idle no request strobe leaves the block
    a_r10_quiet_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_IDLE) |-> (!bus_start && !bus_kill));
endmodule

// File: tb/icache_kill_top_tb.sv
module icache_kill_top_tb;
    localparam int AW    = 16;
    localparam int LINES = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          inv_all = 1'b0;
    logic          fetch_req = 1'b0;
    logic [AW-1:2] fetch_addr = '0;
    logic          fetch_ready, rsp_valid, bus_start, bus_kill;
    logic [31:0]   rsp_data;
    logic [AW-1:2] bus_addr;
    logic          bus_beat_valid = 1'b0;
    logic [31:0]   bus_beat_data = '0;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic       m_valid [LINES];
    logic [8:0] m_tag   [LINES];

    always #2.5 clk = ~clk;

    icache_kill_top #(.AW(AW), .LINES(LINES)) u_dut (
        .clk(clk), .rst_n(rst_n), .inv_all(inv_all),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_ready(fetch_ready),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .bus_start(bus_start), .bus_kill(bus_kill), .bus_addr(bus_addr),
        .bus_beat_valid(bus_beat_valid), .bus_beat_data(bus_beat_data)
    );

    function automatic logic [31:0] mem_word(input logic [15:0] a);
        return 32'h5EED_0000 ^ {16'h0, a[15:2], 2'b00} ^ {a[15:2], 18'h0};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic invalidate_all();
        @(negedge clk); inv_all = 1'b1;
        @(posedge clk); #1 inv_all = 1'b0;
        for (int i = 0; i < LINES; i++) m_valid[i] = 1'b0;
    endtask

    // fetch one longword; on a miss run the burst with optional gaps and invalidate at commit
    task automatic fetch(input logic [15:0] a, input int gap, input bit inv_at_commit);
        int idx  = int'(a[6:4]);
        bit hexp = m_valid[idx] && (m_tag[idx] == a[15:7]);
        int crit = int'(a[3:2]);
        @(negedge clk);
        fetch_req = 1'b1; fetch_addr = a[15:2];
        #1;
        check(bus_start == 1'b1, "R2 start", 32'(bus_start), 1);
        check(bus_addr == a[15:2], "R2 addr", 32'(bus_addr), 32'(a[15:2]));
        check(bus_kill == hexp, "R3 kill", 32'(bus_kill), 32'(hexp));
        @(posedge clk); #1 fetch_req = 1'b0;
        if (hexp) begin
            check(rsp_valid && rsp_data == mem_word(a), "R4 hit data", rsp_data, mem_word(a));
            return;
        end
        check(rsp_valid == 1'b0, "R5 no rsp on miss", 32'(rsp_valid), 0);
        check(fetch_ready == 1'b0, "R5 busy", 32'(fetch_ready), 0);
        for (int k = 0; k < 4; k++) begin
            for (int g = 0; g < gap; g++) begin
                @(negedge clk); bus_beat_valid = 1'b0;
            end
            @(negedge clk);
            bus_beat_valid = 1'b1;
            bus_beat_data  = mem_word({a[15:4], 2'(crit + k), 2'b00});
            if (k == 1) begin
                fetch_req = 1'b1; fetch_addr = a[15:2] ^ 14'h0020;
                #1;
                check(!bus_start && !bus_kill, "R10 ignored fetch", 32'(bus_start), 0);
            end
            @(posedge clk); #1 fetch_req = 1'b0;
            if (k == 0)
                check(rsp_valid && rsp_data == mem_word(a), "R6 critical word",
                      rsp_data, mem_word(a));
            else
                check(rsp_valid == 1'b0, "R10 no rsp", 32'(rsp_valid), 0);
        end
        @(negedge clk); bus_beat_valid = 1'b0; inv_all = inv_at_commit;
        #1 check(fetch_ready == 1'b0, "R7 busy in commit", 32'(fetch_ready), 0);
        @(posedge clk); #1 inv_all = 1'b0;
        check(fetch_ready == 1'b1, "R7 ready after commit", 32'(fetch_ready), 1);
        if (inv_at_commit) begin
            for (int i = 0; i < LINES; i++) m_valid[i] = 1'b0;
        end else begin
            m_valid[idx] = 1'b1; m_tag[idx] = a[15:7];
        end
    endtask

    task automatic expect_hit(input logic [15:0] a, input bit h, input string req);
        int idx = int'(a[6:4]);
        bit m   = m_valid[idx] && (m_tag[idx] == a[15:7]);
        check(m == h, req, 32'(m), 32'(h));
        fetch(a, 0, 1'b0);
    endtask

    task automatic test_reset();
        check(fetch_ready == 1'b1, "R1 ready", 32'(fetch_ready), 1);
        check(rsp_valid == 1'b0, "R1 rsp", 32'(rsp_valid), 0);
        check(bus_start == 1'b0, "R1 start", 32'(bus_start), 0);
        fetch(16'h0040, 0, 1'b0);
    endtask

    task automatic test_line_fill();
        for (int w = 0; w < 4; w++) expect_hit(16'h0040 + 16'(4 * w), 1'b1, "R7 hit");
        fetch(16'h0108, 2, 1'b0);
        for (int w = 0; w < 4; w++) expect_hit(16'h010C - 16'(4 * w), 1'b1, "R5 wrap");
    endtask

    task automatic test_conflict();
        fetch(16'h00C4, 1, 1'b0);
        expect_hit(16'h00C8, 1'b1, "R8 new line");
        expect_hit(16'h0040, 1'b0, "R8 evicted");
    endtask

    task automatic test_invalidate();
        invalidate_all();
        expect_hit(16'h0100, 1'b0, "R9 cleared");
        invalidate_all();
        fetch(16'h0104, 0, 1'b1);
        expect_hit(16'h0104, 1'b0, "R9 commit lost");
        expect_hit(16'h010C, 1'b1, "R9 refilled");
    endtask

    initial begin
        for (int i = 0; i < LINES; i++) begin
            m_valid[i] = 1'b0; m_tag[i] = '0;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        test_reset();
        test_line_fill();
        test_conflict();
        test_invalidate();
        repeat (2) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule